// File: doc/BRIEF.md
# Converter Serial Control and Power Sequencer

This block is the digital front end of a 16-channel, 12-bit sampling converter. A host talks to it through a framed serial slave port with four signals: an active-low select, a serial clock, data in and data out. The data out pin has an enable so that it can go to high impedance. Each frame is 16 serial clocks long. During a frame the block shifts out the most recent conversion result, tagged with its 4-bit channel address. At the same time it accepts a 12-bit configuration word. If the previous accepted write asked for it, the frame instead fills a 16-bit shadow word.

The block also sequences power. A 2-bit mode field in the configuration word selects one of three modes:

- Always on.
- Full shutdown, which holds until a write changes the mode.
- Automatic shutdown, which sleeps between frames and wakes when a frame opens.

The block drives the track/hold control and counts a power-up delay and a quiet time in system clock cycles. The analog core is modelled by a start pulse and a parallel result input. Select and serial clock pass through synchronisers into the system clock domain.

Top module: `adc_serial_front`

## Requirements
- R1: After reset the configuration word is 0x030, so the mode field is 11. The shadow word is 0, the block is powered and ready, track is 1, and dout and dout_en are 0.
- R2: The first 12 data-in bits of a frame, MSB first and sampled on serial clock rising edges, replace the configuration word only when their first bit (bit 11, write enable) is 1. Otherwise the configuration word is unchanged.
- R3: An accepted write with bit 10 = 0 and bit 3 = 1 arms a shadow frame. In the next frame all 16 data-in bits go to the shadow word and the configuration word is left unchanged. A single shadow frame disarms it, and a write with bit 10 = 1 does not arm it.
- R4: dout carries 16 bits, MSB first: the channel address (configuration bits 9:6 at that conversion's start) followed by the 12-bit result of the latest completed conversion. The first bit appears at the select falling edge, and each later bit follows a serial clock falling edge. dout_en is 1 from the select falling edge until the 16th falling edge, and dout is 0 whenever dout_en is 0.
- R5: Inside a frame, track is 0 until the 14th serial clock falling edge and returns to 1 after it while the block is powered.
- R6: Each select falling edge gives exactly one single-cycle conv_start pulse.
- R7: With mode 10 (bits 5:4) in force at a select rising edge, the block powers down (powered = 0, track = 0). It stays down, keeping the configuration word, through frames that do not write a new mode.
- R8: A write of mode 11 while powered down starts power-up at the frame's select rising edge. ready and powered stay 0 for PWRUP_CYC cycles and then return to 1.
- R9: With mode 01, the block powers down at each select rising edge and starts powering up at the next select falling edge. That frame is flagged invalid, and track still returns to 1 after the 14th falling edge once power-up has finished.
- R10: data_invalid holds, for a whole frame, whether the block was not ready at that frame's select falling edge.
- R11: After each select rising edge, ready stays 0 for QUIET_CYC system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Frame select, active low, asynchronous |
| sclk | input | 1 | Serial clock, idles low, asynchronous |
| din | input | 1 | Serial data in, sampled on sclk rising edges |
| conv_result | input | 12 | Result from the conversion core |
| conv_valid | input | 1 | Pulse: conv_result holds a completed conversion |
| dout | output | 1 | Serial data out |
| dout_en | output | 1 | Output enable for the dout pad; 0 means high impedance |
| track | output | 1 | Track/hold control: 1 track, 0 hold |
| conv_start | output | 1 | Pulse that starts a conversion in the core |
| powered | output | 1 | Converter fully powered |
| ready | output | 1 | A new frame may start |
| data_invalid | output | 1 | The current frame started while not ready |
| ctrl_word | output | 12 | Configuration word |
| shadow_word | output | 16 | Shadow word |

## Verification
The bench builds the block with a power-up delay of 40 and a quiet time of 30 system cycles. Each frame takes about 300 system cycles, so both windows fit inside one inter-frame gap. This lets the bench probe ready and powered on both sides of each window. The short delay also means an automatic-shutdown frame finishes waking well before its 14th serial clock falling edge, so the return to track is observable inside that frame.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;
  localparam int CTRL_W  = 12;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 4;
  localparam int RES_W   = 12;

  localparam logic [1:0] PM_NORMAL   = 2'b11;
  localparam logic [1:0] PM_FULL_OFF = 2'b10;
  localparam logic [1:0] PM_AUTO_OFF = 2'b01;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 12'h030;

  typedef enum logic [1:0] {PW_ON, PW_OFF, PW_WAKE} pwr_state_t;

  function automatic logic cw_write(input logic [CTRL_W-1:0] c);
    return c[11];
  endfunction

  function automatic logic [1:0] cw_mode(input logic [CTRL_W-1:0] c);
    return c[5:4];
  endfunction

  function automatic logic [ADDR_W-1:0] cw_addr(input logic [CTRL_W-1:0] c);
    return c[9:6];
  endfunction

  function automatic logic cw_arms_shadow(input logic [CTRL_W-1:0] c);
    return !c[10] && c[3];
  endfunction

  function automatic logic mode_sleeps(input logic [1:0] m);
    return (m == PM_FULL_OFF) || (m == PM_AUTO_OFF);
  endfunction
endpackage

// File: rtl/adcfe_sync.sv
module adcfe_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= INIT;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/adcfe_edge.sv
module adcfe_edge #(
  parameter int W = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= INIT;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/adcfe_frame.sv
module adcfe_frame
  import adcfe_pkg::*;
#(
  parameter int TRACK_EDGE = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_fall,
  input  logic               cs_rise,
  input  logic               sclk_rise,
  input  logic               sclk_fall,
  input  logic               din_s,
  input  logic [FRAME_W-1:0] load_word,
  output logic               in_frame,
  output logic               dout,
  output logic               dout_en,
  output logic               conv_start,
  output logic               hold_phase,
  output logic               ctrl_evt,
  output logic               full_evt,
  output logic [FRAME_W-1:0] word_in
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [CNT_W-1:0]   rise_cnt, fall_cnt;
  logic [FRAME_W-2:0] in_sr;
  logic [FRAME_W-1:0] out_sr;
  logic               take_bit;

  assign take_bit = in_frame && sclk_rise && (rise_cnt < CNT_W'(FRAME_W));
  assign word_in  = {in_sr, din_s};
  assign ctrl_evt = take_bit && (rise_cnt == CNT_W'(CTRL_W - 1));
  assign full_evt = take_bit && (rise_cnt == CNT_W'(FRAME_W - 1));
  assign hold_phase = in_frame && (fall_cnt < CNT_W'(TRACK_EDGE));
  assign dout = dout_en & out_sr[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0; dout_en <= 1'b0; conv_start <= 1'b0;
      rise_cnt <= '0; fall_cnt <= '0; in_sr <= '0; out_sr <= '0;
    end else if (cs_fall) begin
      in_frame <= 1'b1; dout_en <= 1'b1; conv_start <= 1'b1;
      rise_cnt <= '0; fall_cnt <= '0; out_sr <= load_word;
    end else begin
      conv_start <= 1'b0;
      if (cs_rise) begin
        in_frame <= 1'b0;
        dout_en  <= 1'b0;
      end else if (in_frame) begin
        if (take_bit) begin
          in_sr    <= word_in[FRAME_W-2:0];
          rise_cnt <= rise_cnt + CNT_W'(1);
        end
        if (sclk_fall && (fall_cnt < CNT_W'(FRAME_W))) begin
          fall_cnt <= fall_cnt + CNT_W'(1);
          out_sr   <= {out_sr[FRAME_W-2:0], 1'b0};
          if (fall_cnt == CNT_W'(FRAME_W - 1)) dout_en <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/adcfe_power.sv
module adcfe_power
  import adcfe_pkg::*;
#(
  parameter int PWRUP_CYC = 2000,
  parameter int QUIET_CYC = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_fall,
  input  logic       cs_rise,
  input  logic [1:0] mode,
  output logic       powered,
  output logic       ready
);
  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam int QW = $clog2(QUIET_CYC + 1);

  pwr_state_t    st;
  logic [PW-1:0] wake_cnt;
  logic [QW-1:0] quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PW_ON; wake_cnt <= '0; quiet_cnt <= '0;
    end else begin
      if (cs_rise) quiet_cnt <= QW'(QUIET_CYC);
      else if (quiet_cnt != '0) quiet_cnt <= quiet_cnt - QW'(1);
      unique case (st)
        PW_ON:
          if (cs_rise && mode_sleeps(mode)) st <= PW_OFF;
        PW_OFF:
          if ((cs_rise && mode == PM_NORMAL) || (cs_fall && mode == PM_AUTO_OFF)) begin
            st       <= PW_WAKE;
            wake_cnt <= PW'(PWRUP_CYC);
          end
        PW_WAKE:
          if (cs_rise && mode_sleeps(mode)) st <= PW_OFF;
          else if (wake_cnt <= PW'(1))      st <= PW_ON;
          else                              wake_cnt <= wake_cnt - PW'(1);
        default: st <= PW_OFF;
      endcase
    end
  end

  assign powered = (st == PW_ON);
  assign ready   = powered && (quiet_cnt == '0);
endmodule

// File: rtl/adc_serial_front.sv
module adc_serial_front
  import adcfe_pkg::*;
#(
  parameter int PWRUP_CYC   = 2000,
  parameter int QUIET_CYC   = 50,
  parameter int SYNC_STAGES = 2,
  parameter int TRACK_EDGE  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [RES_W-1:0]  conv_result,
  input  logic              conv_valid,
  output logic              dout,
  output logic              dout_en,
  output logic              track,
  output logic              conv_start,
  output logic              powered,
  output logic              ready,
  output logic              data_invalid,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [FRAME_W-1:0] shadow_word
);
  logic [2:0] sync_q;
  logic [1:0] lvl_rise, lvl_fall;
  logic cs_fall, cs_rise, sclk_rise, sclk_fall, din_s;
  logic in_frame, hold_phase, ctrl_evt, full_evt;
  logic ctrl_wr, shadow_wr, shadow_armed, frame_shadow;
  logic [FRAME_W-1:0] word_in, res_word;
  logic [ADDR_W-1:0]  start_addr;

  adcfe_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({din, sclk, cs_n}), .q(sync_q));

  adcfe_edge #(.W(2), .INIT(2'b01)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sync_q[1:0]), .rise(lvl_rise), .fall(lvl_fall));

  assign cs_rise   = lvl_rise[0];
  assign cs_fall   = lvl_fall[0];
  assign sclk_rise = lvl_rise[1];
  assign sclk_fall = lvl_fall[1];
  assign din_s     = sync_q[2];

  adcfe_frame #(.TRACK_EDGE(TRACK_EDGE)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din_s(din_s),
    .load_word(res_word), .in_frame(in_frame), .dout(dout), .dout_en(dout_en),
    .conv_start(conv_start), .hold_phase(hold_phase), .ctrl_evt(ctrl_evt),
    .full_evt(full_evt), .word_in(word_in));

  adcfe_power #(.PWRUP_CYC(PWRUP_CYC), .QUIET_CYC(QUIET_CYC)) u_power (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .mode(cw_mode(ctrl_word)), .powered(powered), .ready(ready));

  assign ctrl_wr   = ctrl_evt && !frame_shadow && cw_write(word_in[CTRL_W-1:0]);
  assign shadow_wr = full_evt && frame_shadow;
  assign track     = powered && !hold_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_word <= CTRL_RESET; shadow_word <= '0; shadow_armed <= 1'b0;
      frame_shadow <= 1'b0; data_invalid <= 1'b0; res_word <= '0; start_addr <= '0;
    end else begin
      if (cs_fall) begin
        frame_shadow <= shadow_armed;
        data_invalid <= !ready;
        start_addr   <= cw_addr(ctrl_word);
      end
      if (ctrl_wr) begin
        ctrl_word    <= word_in[CTRL_W-1:0];
        shadow_armed <= cw_arms_shadow(word_in[CTRL_W-1:0]);
      end
      if (shadow_wr) begin
        shadow_word  <= word_in;
        shadow_armed <= 1'b0;
      end
      if (conv_valid) res_word <= {start_addr, conv_result};
    end
  end
endmodule

// File: rtl/adcfe_chk.sv
module adcfe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        track,
  input logic        powered,
  input logic        ready,
  input logic        dout,
  input logic        dout_en,
  input logic        conv_start,
  input logic        in_frame,
  input logic        hold_phase,
  input logic        cs_rise,
  input logic        ctrl_wr,
  input logic        shadow_wr,
  input logic [11:0] ctrl_word,
  input logic [15:0] shadow_word
);
  a_r2_ctrl_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_word));
  a_r3_shadow_only_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow_wr |=> $stable(shadow_word));
  a_r4_dout_low_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> !dout);
  a_r4_enable_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> in_frame);
  a_r5_hold_before_edge: assert property (@(posedge clk) disable iff (!rst_n)
    hold_phase |-> !track);
  a_r6_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  a_r7_unpowered_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !powered |-> !track);
  a_r8_ready_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> powered);
  a_r11_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !ready);
endmodule

bind adc_serial_front adcfe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .track(track), .powered(powered), .ready(ready),
  .dout(dout), .dout_en(dout_en), .conv_start(conv_start), .in_frame(in_frame),
  .hold_phase(hold_phase), .cs_rise(cs_rise), .ctrl_wr(ctrl_wr),
  .shadow_wr(shadow_wr), .ctrl_word(ctrl_word), .shadow_word(shadow_word));

// File: tb/adc_serial_front_test.sv
module adc_serial_front_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, conv_valid = 1'b0;
  logic [11:0] conv_result = '0;
  logic dout, dout_en, track, conv_start, powered, ready, data_invalid;
  logic [11:0] ctrl_word;
  logic [15:0] shadow_word;

  int n_checks = 0, n_errors = 0, n_starts = 0;
  localparam int H = 6;

  always #5 clk = ~clk;

  adc_serial_front #(.PWRUP_CYC(40), .QUIET_CYC(30)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .conv_result(conv_result), .conv_valid(conv_valid), .dout(dout),
    .dout_en(dout_en), .track(track), .conv_start(conv_start),
    .powered(powered), .ready(ready), .data_invalid(data_invalid),
    .ctrl_word(ctrl_word), .shadow_word(shadow_word));

  always @(posedge clk) if (conv_start) n_starts++;

  // entry: din word, core result, expected ctrl, expected shadow
  localparam logic [55:0] VEC [7] = '{
    {16'h9700, 12'hABC, 12'h970, 16'h0000},
    {16'h3FF0, 12'h123, 12'h970, 16'h0000},
    {16'hAB35, 12'hFFF, 12'hAB3, 16'h0000},
    {16'h8F80, 12'h001, 12'h8F8, 16'h0000},
    {16'hC3A5, 12'h800, 12'h8F8, 16'hC3A5},
    {16'hC380, 12'h7FF, 12'hC38, 16'hC3A5},
    {16'h9701, 12'h456, 12'h970, 16'hC3A5}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic frame(input logic [15:0] w, input logic [11:0] res,
                       output logic [15:0] got, output logic t13, output logic t14,
                       output logic en_first, output logic en_last);
    cs_n = 1'b0;
    wait_clk(8);
    conv_result = res; conv_valid = 1'b1;
    wait_clk(1);
    conv_valid = 1'b0;
    en_first = dout_en;
    for (int i = 0; i < 16; i++) begin
      got[15-i] = dout;
      din = w[15-i];
      wait_clk(H); sclk = 1'b1;
      wait_clk(H); sclk = 1'b0;
      wait_clk(H);
      if (i == 12) t13 = track;
      if (i == 13) t14 = track;
      if (i == 15) en_last = dout_en;
    end
    wait_clk(4);
    cs_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [15:0] got;
    logic t13, t14, e1, e16;
    logic [3:0] prev_addr;
    logic [11:0] prev_res, model_ctrl;
    int s0;
    prev_addr = '0; prev_res = '0; model_ctrl = 12'h030;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R1 reset state
    check("R1 ctrl", ctrl_word, 12'h030);
    check("R1 shadow", shadow_word, 16'h0);
    check("R1 powered/ready/track", {powered, ready, track}, 3'b111);
    check("R1 dout/dout_en", {dout, dout_en}, 2'b00);

    // table walk: R2 R3 R4 R5 R6
    for (int k = 0; k < 7; k++) begin
      s0 = n_starts;
      frame(VEC[k][55:40], VEC[k][39:28], got, t13, t14, e1, e16);
      wait_clk(60);
      check("R4 dout frame", got, {prev_addr, prev_res});
      check("R2 ctrl after frame", ctrl_word, VEC[k][27:16]);
      check("R3 shadow after frame", shadow_word, VEC[k][15:0]);
      check("R5 hold before 14th fall", t13, 1'b0);
      check("R5 track after 14th fall", t14, 1'b1);
      check("R6 one start per frame", n_starts - s0, 1);
      check("R10 valid frame", data_invalid, 1'b0);
      prev_addr = model_ctrl[9:6];
      prev_res = VEC[k][39:28];
      model_ctrl = VEC[k][27:16];
    end
    check("R4 enable at start", e1, 1'b1);
    check("R4 released after 16th fall", e16, 1'b0);
    check("R4 idle dout_en", dout_en, 1'b0);

    // R11 quiet time and R10 early frame
    frame(16'h0000, 12'h111, got, t13, t14, e1, e16);
    wait_clk(10);
    check("R11 not ready in quiet time", ready, 1'b0);
    frame(16'h0000, 12'h222, got, t13, t14, e1, e16);
    check("R10 early frame invalid", data_invalid, 1'b1);
    wait_clk(60);
    check("R11 ready after quiet time", ready, 1'b1);
    frame(16'h0000, 12'h333, got, t13, t14, e1, e16);
    check("R10 on-time frame valid", data_invalid, 1'b0);
    wait_clk(60);

    // R7 full shutdown
    frame(16'h8200, 12'h000, got, t13, t14, e1, e16);
    wait_clk(15);
    check("R7 powered down", {powered, track}, 2'b00);
    wait_clk(300);
    check("R7 stays down", powered, 1'b0);
    frame(16'h0000, 12'h000, got, t13, t14, e1, e16);
    wait_clk(15);
    check("R7 still down, ctrl kept", {powered, ctrl_word}, {1'b0, 12'h820});
    check("R7 no track in shutdown", t14, 1'b0);
    check("R10 frame while down invalid", data_invalid, 1'b1);

    // R8 power-up
    frame(16'h8300, 12'h000, got, t13, t14, e1, e16);
    wait_clk(15);
    check("R8 waking not ready", {powered, ready}, 2'b00);
    wait_clk(60);
    check("R8 powered after delay", {powered, ready}, 2'b11);

    // R9 automatic shutdown
    frame(16'h8100, 12'h000, got, t13, t14, e1, e16);
    wait_clk(15);
    check("R9 sleeps after frame", powered, 1'b0);
    wait_clk(60);
    check("R9 asleep between frames", powered, 1'b0);
    frame(16'h0000, 12'h000, got, t13, t14, e1, e16);
    check("R9 wake frame invalid", data_invalid, 1'b1);
    check("R9 track after wake", t14, 1'b1);
    wait_clk(15);
    check("R9 sleeps again", powered, 1'b0);
    wait_clk(60);
    frame(16'h8300, 12'h000, got, t13, t14, e1, e16);
    wait_clk(60);
    check("R8 normal mode restored", {powered, ctrl_word}, {1'b1, 12'h830});

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule